// File: doc/BRIEF.md
# Filtered Last-Branch Record Stack

This block keeps a short history of taken branches as pairs of source and target addresses in a circular stack. Each hardware context has its own stack and its own select register. Software writes the select register to suppress branches by privilege ring and by branch type. Rules keep calls and returns separate from plain jumps. A mode bit turns the history into a call stack: calls push and returns pop.

A retired-branch event carries the context, both addresses, the current ring and a 3-bit type code. Software sets the filter through a write port and reads it back through a combinational read path. A separate combinational port returns any stack entry and the top-of-stack pointer of a chosen context.

Top module: `lbr_stack`

## Requirements
- R1: After reset every select register reads zero, every top-of-stack pointer is 0 and every stack entry is invalid.
- R2: Select bit 0 set discards branches taken in ring 0. Select bit 1 set discards branches taken in any ring above 0.
- R3: Type codes are 0 conditional, 1 near relative call, 2 near indirect call, 3 near return, 4 near indirect jump, 5 near relative jump and 6 far branch. Select bit (code+2) set discards branches of that code.
- R4: Select bit 6 has no effect on codes 2 and 3. Select bit 7 has no effect on code 1.
- R5: A branch with type code 7 is never recorded.
- R6: With select bit 9 clear, a kept branch moves the context's pointer up by one modulo DEPTH. It then writes its addresses into the entry the pointer now names and marks that entry valid, so on wrap the oldest entry is overwritten.
- R7: With select bit 9 set, a kept call (code 1 or 2) pushes as in R6. A kept return (code 3) invalidates the top entry and moves the pointer down by one. Kept branches of the other codes change nothing.
- R8: In call-stack mode, a kept return whose top entry is invalid leaves the pointer and all entries unchanged.
- R9: A write that sets any bit from 10 upward is rejected and leaves the select register unchanged.
- R10: Each context's select register filters only the branches of that context and changes only that context's stack.
- R11: A select write takes effect from the next cycle. A branch in the same cycle as the write is filtered by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Retired taken branch this cycle |
| br_ctx | input | CW | Context of the branch |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| br_ring | input | 2 | Privilege ring at the branch |
| br_kind | input | 3 | Branch type code |
| cfg_we | input | 1 | Select register write strobe |
| cfg_ctx | input | CW | Context addressed by the write and the readback |
| cfg_wdata | input | SEL_W | Select write value |
| cfg_rdata | output | SEL_W | Select register of cfg_ctx |
| rd_ctx | input | CW | Context for the stack read |
| rd_idx | input | PW | Entry index for the stack read |
| rd_from | output | AW | Source address of the entry |
| rd_to | output | AW | Target address of the entry |
| rd_valid | output | 1 | Entry holds a record |
| rd_tos | output | PW | Top-of-stack pointer of rd_ctx |

## Verification
The readback paths are combinational. cfg_rdata and the rd_* outputs settle within the cycle their select inputs change. A branch event changes the pointer and entries one rising edge after it is driven. A select write filters branches from that same edge on, so its effect shows on a branch driven one cycle later. The bench drives inputs on a falling edge and updates its model at the next rising edge. It reads the outputs after the falling edge that follows, with a short settling delay after each change of the read selectors.

// File: rtl/lbr_stack.sv
module lbr_stack #(
  parameter int AW     = 32,
  parameter int DEPTH  = 16,
  parameter int NCTX   = 2,
  parameter int SEL_W  = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int DEF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [CW-1:0]    br_ctx,
  input  logic [AW-1:0]    br_from,
  input  logic [AW-1:0]    br_to,
  input  logic [1:0]       br_ring,
  input  logic [2:0]       br_kind,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_ctx,
  input  logic [SEL_W-1:0] cfg_wdata,
  output logic [SEL_W-1:0] cfg_rdata,
  input  logic [CW-1:0]    rd_ctx,
  input  logic [PW-1:0]    rd_idx,
  output logic [AW-1:0]    rd_from,
  output logic [AW-1:0]    rd_to,
  output logic             rd_valid,
  output logic [PW-1:0]    rd_tos
);
  localparam int B_CS = 9;

  logic [NCTX-1:0][SEL_W-1:0] sel_q;
  logic [NCTX-1:0][PW-1:0]    tos_q;
  logic [NCTX-1:0][DEPTH-1:0] val_q;
  logic [AW-1:0] from_m [NCTX][DEPTH];
  logic [AW-1:0] to_m   [NCTX][DEPTH];

  logic [SEL_W-1:0] bsel;
  logic [PW-1:0]    cur, nxt, prv;
  logic ring_drop, kind_drop, keep, is_call, is_ret, cs, do_push, do_pop, cfg_ok;

  assign bsel      = sel_q[br_ctx];
  assign cur       = tos_q[br_ctx];
  assign nxt       = cur + 1'b1;
  assign prv       = cur - 1'b1;
  assign ring_drop = (br_ring == 2'd0) ? bsel[0] : bsel[1];
  assign kind_drop = (br_kind == 3'd7) ? 1'b1 : bsel[4'(br_kind) + 4'd2];
  assign keep      = br_valid && !ring_drop && !kind_drop;
  assign is_call   = (br_kind == 3'd1) || (br_kind == 3'd2);
  assign is_ret    = (br_kind == 3'd3);
  assign cs        = bsel[B_CS];
  assign do_push   = keep && (!cs || is_call);
  assign do_pop    = keep && cs && is_ret && val_q[br_ctx][cur];
  assign cfg_ok    = cfg_we && (cfg_wdata[SEL_W-1:DEF_W] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      tos_q <= '0;
      val_q <= '0;
    end else begin
      if (cfg_ok) sel_q[cfg_ctx] <= cfg_wdata;
      if (do_push) begin
        tos_q[br_ctx]      <= nxt;
        val_q[br_ctx][nxt] <= 1'b1;
      end else if (do_pop) begin
        tos_q[br_ctx]      <= prv;
        val_q[br_ctx][cur] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      from_m[br_ctx][nxt] <= br_from;
      to_m[br_ctx][nxt]   <= br_to;
    end
  end

  assign cfg_rdata = sel_q[cfg_ctx];
  assign rd_from   = from_m[rd_ctx][rd_idx];
  assign rd_to     = to_m[rd_ctx][rd_idx];
  assign rd_valid  = val_q[rd_ctx][rd_idx];
  assign rd_tos    = tos_q[rd_ctx];

  a_r9_reserved_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[SEL_W-1:DEF_W] != '0)) |=> (sel_q == $past(sel_q)));

  a_r2_ring0_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ring == 2'd0 && sel_q[br_ctx][0]) |=>
      (tos_q == $past(tos_q) && val_q == $past(val_q)));

  a_r6_normal_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd0 && !sel_q[br_ctx][2] && !sel_q[br_ctx][B_CS] &&
     !sel_q[br_ctx][(br_ring == 2'd0) ? 0 : 1]) |=>
      (tos_q[$past(br_ctx)] == PW'($past(tos_q[br_ctx]) + 1'b1)) &&
      val_q[$past(br_ctx)][tos_q[$past(br_ctx)]]);

  a_r4_indcall_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd2 && !sel_q[br_ctx][4] &&
     !sel_q[br_ctx][(br_ring == 2'd0) ? 0 : 1]) |=>
      (tos_q[$past(br_ctx)] == PW'($past(tos_q[br_ctx]) + 1'b1)));

  a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind == 3'd3 && sel_q[br_ctx][B_CS] &&
     !val_q[br_ctx][tos_q[br_ctx]]) |=>
      (tos_q == $past(tos_q) && val_q == $past(val_q)));
endmodule

// File: tb/lbr_stack_bench.sv
`timescale 1ns/1ps
module lbr_stack_bench;
  localparam int AW = 32, DEPTH = 16, NCTX = 2, SEL_W = 16, PW = 4, CW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 1'b0;
  logic [CW-1:0] br_ctx = '0, cfg_ctx = '0, rd_ctx = '0;
  logic [AW-1:0] br_from = '0, br_to = '0;
  logic [1:0] br_ring = '0;
  logic [2:0] br_kind = '0;
  logic cfg_we = 1'b0;
  logic [SEL_W-1:0] cfg_wdata = '0, cfg_rdata;
  logic [PW-1:0] rd_idx = '0, rd_tos;
  logic [AW-1:0] rd_from, rd_to;
  logic rd_valid;

  always #10 clk = ~clk;

  lbr_stack u_lbr_stack (.*);

  int n_chk = 0, n_fail = 0;
  logic [SEL_W-1:0] msel [NCTX];
  logic [PW-1:0]    mtos [NCTX];
  logic             mval [NCTX][DEPTH];
  logic [AW-1:0]    mfrom [NCTX][DEPTH];
  logic [AW-1:0]    mto   [NCTX][DEPTH];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit dropped(logic [SEL_W-1:0] s, logic [1:0] ring, logic [2:0] kind);
    if ((ring == 0) ? s[0] : s[1]) return 1'b1;
    if (kind == 3'd7) return 1'b1;
    return s[kind + 2];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCTX; c++) begin
      msel[c] = '0; mtos[c] = '0;
      for (int i = 0; i < DEPTH; i++) mval[c][i] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); model_reset();
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic step(bit v, int ctx, logic [AW-1:0] f, logic [AW-1:0] t,
                      logic [1:0] ring, logic [2:0] kind,
                      bit we, int wctx, logic [SEL_W-1:0] wd);
    logic [PW-1:0] n;
    br_valid = v; br_ctx = CW'(ctx); br_from = f; br_to = t; br_ring = ring; br_kind = kind;
    cfg_we = we; cfg_ctx = CW'(wctx); cfg_wdata = wd;
    @(posedge clk);
    if (v && !dropped(msel[ctx], ring, kind)) begin
      if (!msel[ctx][9] || kind == 3'd1 || kind == 3'd2) begin
        n = mtos[ctx] + 1'b1;
        mtos[ctx] = n; mval[ctx][n] = 1'b1; mfrom[ctx][n] = f; mto[ctx][n] = t;
      end else if (kind == 3'd3 && mval[ctx][mtos[ctx]]) begin
        mval[ctx][mtos[ctx]] = 1'b0;
        mtos[ctx] = mtos[ctx] - 1'b1;
      end
    end
    if (we && wd[SEL_W-1:10] == '0) msel[wctx] = wd;
    @(negedge clk);
    br_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic br(int ctx, logic [1:0] ring, logic [2:0] kind);
    step(1'b1, ctx, $urandom, $urandom, ring, kind, 1'b0, 0, '0);
  endtask

  task automatic wr(int ctx, logic [SEL_W-1:0] wd);
    step(1'b0, 0, '0, '0, 2'd0, 3'd0, 1'b1, ctx, wd);
  endtask

  task automatic check_tos(string tag);
    for (int c = 0; c < NCTX; c++) begin
      rd_ctx = CW'(c); cfg_ctx = CW'(c); #1;
      chk(tag, 64'(rd_tos), 64'(mtos[c]));
      chk(tag, 64'(cfg_rdata), 64'(msel[c]));
    end
  endtask

  task automatic check_all(string tag);
    check_tos(tag);
    for (int c = 0; c < NCTX; c++) begin
      rd_ctx = CW'(c);
      for (int i = 0; i < DEPTH; i++) begin
        rd_idx = PW'(i); #1;
        chk(tag, 64'(rd_valid), 64'(mval[c][i]));
        if (mval[c][i]) begin
          chk(tag, 64'(rd_from), 64'(mfrom[c][i]));
          chk(tag, 64'(rd_to), 64'(mto[c][i]));
        end
      end
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset state");
    chk("R1 tos", 64'(rd_tos), 64'd0);

    wr(0, 16'h0004);
    wr(0, 16'h0400);
    cfg_ctx = '0; #1;
    chk("R9 reserved write rejected", 64'(cfg_rdata), 64'h0004);
    check_all("R9");

    wr(0, 16'h0001);
    br(0, 2'd0, 3'd0); br(0, 2'd3, 3'd0);
    check_all("R2 ring0 filter");
    wr(0, 16'h0002);
    br(0, 2'd2, 3'd0); br(0, 2'd0, 3'd0); br(0, 2'd1, 3'd6);
    check_all("R2 ring>0 filter");

    for (int k = 0; k < 7; k++) begin
      wr(0, SEL_W'(1) << (k + 2));
      br(0, 2'd0, 3'(k));
      br(0, 2'd0, 3'((k + 1) % 7));
      check_all("R3 type filter");
    end

    wr(0, 16'h00C0);
    br(0, 2'd0, 3'd1); br(0, 2'd0, 3'd2); br(0, 2'd0, 3'd3);
    br(0, 2'd0, 3'd4); br(0, 2'd0, 3'd5);
    check_all("R4 jump bits spare calls and returns");

    wr(0, 16'h0000);
    br(0, 2'd0, 3'd7); br(0, 2'd3, 3'd7);
    check_all("R5 code 7 ignored");

    for (int i = 0; i < 20; i++) br(0, 2'(i), 3'(i % 7));
    check_all("R6 wrap");

    wr(1, 16'h0004);
    br(0, 2'd0, 3'd0); br(1, 2'd0, 3'd0); br(1, 2'd0, 3'd1);
    check_all("R10 context isolation");

    step(1'b1, 0, 32'h1111, 32'h2222, 2'd0, 3'd0, 1'b1, 0, 16'h0004);
    check_all("R11 same-cycle write uses old value");
    br(0, 2'd0, 3'd0);
    check_all("R11 write effective next cycle");

    do_reset();
    check_all("R1 after second reset");
    wr(0, 16'h0200);
    br(0, 2'd0, 3'd1); br(0, 2'd0, 3'd2); br(0, 2'd0, 3'd0); br(0, 2'd0, 3'd4);
    br(0, 2'd0, 3'd1);
    check_all("R7 pushes");
    br(0, 2'd0, 3'd3);
    check_all("R7 pop");
    br(0, 2'd0, 3'd3); br(0, 2'd0, 3'd3);
    check_all("R7 pop to empty");
    br(0, 2'd0, 3'd3);
    check_all("R8 pop on empty");
    chk("R8 tos stays", 64'(rd_tos), 64'd0);

    for (int i = 0; i < 3000; i++) begin
      bit we;
      logic [SEL_W-1:0] wd;
      we = ($urandom % 10) == 0;
      wd = (($urandom % 8) == 0) ? SEL_W'($urandom) : (SEL_W'($urandom) & 16'h03FF & ~16'h0003);
      step(($urandom % 4) != 0, $urandom % NCTX, $urandom, $urandom, 2'($urandom),
           (($urandom % 3) == 0) ? 3'd3 : 3'($urandom), we, $urandom % NCTX, wd);
      check_tos("random R6 R7 pointer");
      if (i % 100 == 99) check_all("random R6 R7 entries");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule